// File: doc/BRIEF.md
# Fault Flag Register with Write Locks

This block keeps a bank of sticky fault and event flags for a supervisory device. Internal detectors each raise a one-cycle set pulse on their own line. The matching flag then stays set until software writes a 1 to its bit. While any interrupt-enabled flag is set, the active-low interrupt output is held low. A subset of flags, the severe faults, also pulls the active-low reset output low. A force bit in the control group lets software drive the interrupt output low with no flag set.

The configuration registers are split into seven groups: work, three sequence groups, watchdog, alarm clock and control. Each group has one lock bit. Software can set a lock bit but cannot clear it, and only a reset clears it. While a group's lock bit is set, writes to that group's register are dropped. The flag register, the status register and the lock register are never locked. Access is through a simple port: a write strobe with address and data, and a combinational read bus selected by the same address.

Register map (4-bit address): 0 = flags (write 1 to clear), 1 = status (read only), 2 = locks (write 1 to set), 3..9 = group registers in the order work, seq_up, seq_dn, seq_cfg, wdog, alarm, ctl. Flag bit positions: 0 internal, 1 emergency power-down, 2 watchdog, 3 packet check, 4 alarm, 5 enable-pin, 6 oscillator, 7 pin readback, 8 self-test, 9 regulator, 10 thermal, 11 runtime CRC, 12 ECC double error, 13 short button press.

Top module: `fault_flag_reg`

## Requirements
- R1: After reset every flag, lock and group register reads 0, irq_n is 1 and rst_n is 1.
- R2: A set pulse on set_pulse[i] makes flag bit i read 1 from the next clock edge on, and the bit stays 1 after the pulse ends.
- R3: A write to address 0 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set. A clearing write on another bit in that cycle still takes effect.
- R5: irq_n is 0 while any flag is set and 1 when no flag is set and the force bit is 0.
- R6: rst_n is 0 while any of flags 5, 8, 9, 10 or 12 is set. The other flags do not change rst_n.
- R7: Bit 0 of the control group register (address 9) is the force bit. Writing 1 to it drives irq_n to 0 with all flags clear, and writing 0 releases it.
- R8: Writing the lock register (address 2) sets each lock bit whose data bit is 1. Writing 0 never clears a lock bit, and only reset clears it. Lock bit g guards group register 3+g.
- R9: A write to a group register whose lock bit is set leaves the register unchanged. Writes to unlocked groups still take effect.
- R10: The status register (address 1) reads bit 0 = 1 while irq_n is low and bit 1 = 1 while rst_n is low. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| set_pulse | input | 14 | One set line per flag, active high |
| irq_n | output | 1 | Active-low interrupt output |
| rst_n | output | 1 | Active-low reset output |

## Verification
The flags are driven with three kinds of stimulus: single set pulses on non-reset flags, pulses on each reset-routed flag, and a same-cycle set plus clear. Single pulses separate the interrupt path from the reset path. The reset-routed pulses confirm the routing mask bit by bit. The same-cycle case shows whether set has priority without blocking a clear on a neighbouring bit. Lock patterns write a group before and after its lock is set, write an unlocked neighbour, and write 0 to the lock register. Together these separate per-group gating from a global freeze and from a lock that can be cleared.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

    localparam int NFLAG  = 14;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int NGRP   = 7;

    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd1;
    localparam logic [ADDR_W-1:0] A_LOCKS  = 4'd2;
    localparam logic [ADDR_W-1:0] A_GRP0   = 4'd3;

    typedef enum logic [2:0] {
        G_WORK    = 3'd0,
        G_SEQ_UP  = 3'd1,
        G_SEQ_DN  = 3'd2,
        G_SEQ_CFG = 3'd3,
        G_WDOG    = 3'd4,
        G_ALARM   = 3'd5,
        G_CTL     = 3'd6
    } grp_e;

    localparam int FORCE_BIT = 0;

    // flags that drive the reset output: enable-pin, self-test, regulator, thermal, ECC DED
    localparam logic [NFLAG-1:0] RST_MASK = 14'b01_0111_0010_0000;
    localparam logic [NFLAG-1:0] IRQ_MASK = {NFLAG{1'b1}};

    typedef logic [NGRP-1:0][DATA_W-1:0] grp_arr_t;

    typedef struct packed {
        logic irq_act;
        logic rst_act;
    } pin_state_t;

    function automatic logic [DATA_W-1:0] status_word(pin_state_t p);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = p.irq_act;
        w[1] = p.rst_act;
        return w;
    endfunction

    function automatic logic in_grp_range(logic [ADDR_W-1:0] a);
        return (a >= A_GRP0) && (int'(a) < int'(A_GRP0) + NGRP);
    endfunction

endpackage

// File: rtl/ffr_flag_bank.sv
module ffr_flag_bank #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // set has priority over a clear on the same bit
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/ffr_lock_bank.sv
module ffr_lock_bank #(
    parameter int NG = 7,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lock_wr,
    input  logic [NG-1:0]          lock_bits,
    input  logic [NG-1:0]          grp_wr,
    input  logic [DW-1:0]          wdata,
    output logic [NG-1:0]          locks_o,
    output logic [NG-1:0][DW-1:0]  grp_o
);
    logic [NG-1:0] locks_q;

    always_ff @(posedge clk) begin
        if (rst)          locks_q <= '0;
        else if (lock_wr) locks_q <= locks_q | lock_bits;
    end

    for (genvar g = 0; g < NG; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)                          r_q <= '0;
            else if (grp_wr[g] && !locks_q[g]) r_q <= wdata;
        end
        assign grp_o[g] = r_q;
    end

    assign locks_o = locks_q;
endmodule

// File: rtl/ffr_pin_logic.sv
module ffr_pin_logic
    import ffr_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic             force_irq,
    output logic             irq_n,
    output logic             rst_n,
    output pin_state_t       pins
);
    always_comb begin
        pins.irq_act = (|(flags & IRQ_MASK)) | force_irq;
        pins.rst_act = |(flags & RST_MASK);
        irq_n        = ~pins.irq_act;
        rst_n        = ~pins.rst_act;
    end
endmodule

// File: rtl/fault_flag_reg.sv
module fault_flag_reg
    import ffr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NFLAG-1:0]  set_pulse,
    output logic              irq_n,
    output logic              rst_n
);
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] clr_vec;
    logic [NGRP-1:0]  locks_q;
    logic [NGRP-1:0]  grp_wr;
    grp_arr_t         grp_q;
    logic             force_irq;
    pin_state_t       pins;

    assign clr_vec = (wr_en && addr == A_FLAGS) ? wdata[NFLAG-1:0] : '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_dec
        assign grp_wr[g] = wr_en && (addr == A_GRP0 + ADDR_W'(g));
    end

    ffr_flag_bank #(.N(NFLAG)) u_flags (
        .clk(clk), .rst(rst), .set_i(set_pulse), .clr_i(clr_vec), .flags_o(flags_q)
    );

    ffr_lock_bank #(.NG(NGRP), .DW(DATA_W)) u_locks (
        .clk(clk), .rst(rst),
        .lock_wr(wr_en && addr == A_LOCKS), .lock_bits(wdata[NGRP-1:0]),
        .grp_wr(grp_wr), .wdata(wdata),
        .locks_o(locks_q), .grp_o(grp_q)
    );

    assign force_irq = grp_q[G_CTL][FORCE_BIT];

    ffr_pin_logic u_pins (
        .flags(flags_q), .force_irq(force_irq), .irq_n(irq_n), .rst_n(rst_n), .pins(pins)
    );

    always_comb begin
        rdata = '0;
        if (addr == A_FLAGS)          rdata = DATA_W'(flags_q);
        else if (addr == A_STATUS)    rdata = status_word(pins);
        else if (addr == A_LOCKS)     rdata = DATA_W'(locks_q);
        else if (in_grp_range(addr))  rdata = grp_q[3'(addr - A_GRP0)];
    end
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker
    import ffr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NFLAG-1:0]  set_pulse,
    input logic [NFLAG-1:0]  flags_q,
    input logic [NGRP-1:0]   locks_q,
    input grp_arr_t          grp_q,
    input logic              irq_n,
    input logic              rst_n
);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_FLAGS) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((flags_q & $past(set_pulse)) == $past(set_pulse)));

    assert_irq_on_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (flags_q != '0) |-> !irq_n);

    assert_rst_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((flags_q & RST_MASK) == '0) |-> rst_n);

    assert_lock_keep_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((locks_q & $past(locks_q)) == $past(locks_q)));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        assert_locked_hold_R9: assert property (@(posedge clk) disable iff (rst)
            locks_q[g] |=> $stable(grp_q[g]));
    end
endmodule

bind fault_flag_reg ffr_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .set_pulse(set_pulse),
    .flags_q(flags_q), .locks_q(locks_q), .grp_q(grp_q), .irq_n(irq_n), .rst_n(rst_n)
);

// File: tb/fault_flag_reg_test.sv
module fault_flag_reg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [13:0] set_pulse = '0;
    logic        irq_n, rst_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fault_flag_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .set_pulse(set_pulse), .irq_n(irq_n), .rst_n(rst_n)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(string req, logic [3:0] a, logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(logic [13:0] p);
        @(negedge clk);
        set_pulse = p;
        @(negedge clk);
        set_pulse = '0;
    endtask

    task automatic pins(string req, logic ei, logic er);
        #1;
        chk({req, " irq_n"}, {15'd0, irq_n}, {15'd0, ei});
        chk({req, " rst_n"}, {15'd0, rst_n}, {15'd0, er});
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_R1;
        do_reset();
        pins("R1", 1'b1, 1'b1);
        rd("R1 flags", 4'd0, 16'h0000);
        rd("R1 locks", 4'd2, 16'h0000);
        rd("R1 work", 4'd3, 16'h0000);
        rd("R1 ctl", 4'd9, 16'h0000);
        rd("R10 status idle", 4'd1, 16'h0000);
    endtask

    task automatic t_sticky_R2;
        pulse(14'h0010);
        rd("R2 set", 4'd0, 16'h0010);
        repeat (3) @(negedge clk);
        rd("R2 held", 4'd0, 16'h0010);
        pins("R5/R6 non-reset flag", 1'b0, 1'b1);
        rd("R10 status irq", 4'd1, 16'h0001);
    endtask

    task automatic t_w1c_R3;
        pulse(14'h0041);
        wr(4'd0, 16'h0000);
        rd("R3 zero write", 4'd0, 16'h0051);
        wr(4'd0, 16'h0010);
        rd("R3 partial clear", 4'd0, 16'h0041);
        wr(4'd0, 16'hFFFF);
        rd("R3 full clear", 4'd0, 16'h0000);
        pins("R5 released", 1'b1, 1'b1);
    endtask

    task automatic t_route_R6;
        int rbits[5] = '{5, 8, 9, 10, 12};
        foreach (rbits[k]) begin
            pulse(14'(1) << rbits[k]);
            pins("R6 routed", 1'b0, 1'b0);
            rd("R10 status both", 4'd1, 16'h0003);
            wr(4'd0, 16'(1) << rbits[k]);
            pins("R6 cleared", 1'b1, 1'b1);
        end
        pulse(14'h0800);
        pins("R6 crc not routed", 1'b0, 1'b1);
        wr(4'd0, 16'h0800);
    endtask

    task automatic t_collide_R4;
        pulse(14'h0008);
        @(negedge clk);
        set_pulse = 14'h0004;
        wr_en = 1'b1; addr = 4'd0; wdata = 16'h000C;
        @(negedge clk);
        set_pulse = '0; wr_en = 1'b0;
        rd("R4 set wins, other bit cleared", 4'd0, 16'h0004);
        wr(4'd0, 16'h0004);
        rd("R4 cleared after", 4'd0, 16'h0000);
    endtask

    task automatic t_force_R7;
        wr(4'd9, 16'h0001);
        pins("R7 forced", 1'b0, 1'b1);
        rd("R7 no flags", 4'd0, 16'h0000);
        rd("R10 status forced", 4'd1, 16'h0001);
        wr(4'd9, 16'h0000);
        pins("R7 released", 1'b1, 1'b1);
    endtask

    task automatic t_locks_R8_R9;
        wr(4'd3, 16'hA5A5);
        rd("R9 unlocked write", 4'd3, 16'hA5A5);
        wr(4'd2, 16'h0001);
        rd("R8 lock set", 4'd2, 16'h0001);
        wr(4'd3, 16'h1234);
        rd("R9 locked ignored", 4'd3, 16'hA5A5);
        wr(4'd4, 16'h00FF);
        rd("R9 neighbour writable", 4'd4, 16'h00FF);
        wr(4'd2, 16'h0000);
        rd("R8 zero keeps lock", 4'd2, 16'h0001);
        wr(4'd9, 16'h0001);
        wr(4'd2, 16'h0040);
        rd("R8 second lock", 4'd2, 16'h0041);
        wr(4'd9, 16'h0000);
        pins("R9 ctl locked keeps force", 1'b0, 1'b1);
        pulse(14'h0002);
        wr(4'd0, 16'h0002);
        rd("R9 flag reg never locked", 4'd0, 16'h0000);
        do_reset();
        rd("R8 reset clears locks", 4'd2, 16'h0000);
        pins("R1 after reset", 1'b1, 1'b1);
    endtask

    initial begin
        t_reset_R1();
        t_sticky_R2();
        t_w1c_R3();
        t_route_R6();
        t_collide_R4();
        t_force_R7();
        t_locks_R8_R9();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule